// File: doc/BRIEF.md
# Time-Sliced Pixel Hit Counter

This block is the digital back end of one pixel in a hit-counting detector. A discriminator pulse from the analog front end enters asynchronously. It is synchronized and reduced to a single-cycle hit event on its rising edge. Each event advances an 8-bit counter held in Gray code. The block keeps no amplitude information, only the number of hits.

A bunch train is cut into 16 consecutive time slices by a slice-switch strobe. On each accepted switch, the running count and its overflow flag are written into the storage entry for the current slice. The counter then restarts in that same cycle. The result is a per-pixel histogram of hits over time across the train.

In the long gap between trains, an external controller pulls the 16 stored entries one per read strobe. Entries come out in slice order, converted to plain binary. A train-start strobe rearms the counter, the slice index and the read pointer for the next train.

Top module: `pix_slice_counter`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is 0 and `rd_ovf` is 0.
- R2: Each low-to-high transition of `hit_in` adds exactly one to the count, whatever the width of the high phase.
- R3: The count saturates at binary 255. A hit arriving while saturated leaves the count at 255 and sets the overflow flag stored with that slice. A slice that reaches exactly 255 hits has the flag clear.
- R4: An accepted `slice_switch` stores the current count into the entry of the current slice, starting at slice 0 and advancing by one, and restarts the count from zero. A hit event in the same cycle as the switch is counted in the new slice.
- R5: A `slice_switch` that arrives after 16 switches have been accepted in the current train is ignored and overwrites no stored entry.
- R6: `train_start` clears the running count, the overflow flag, the slice index and the read pointer. Hits seen before it are discarded.
- R7: A one-cycle `rd_strobe` produces `rd_valid` = 1 on the following cycle only. With it come the next entry's count in binary on `rd_data` and its flag on `rd_ovf`. Entries are read from slice 0 upward, and the pointer wraps to slice 0 after slice 15.
- R8: The running count is held in Gray code, so a single increment changes at most one counter bit. Stored counts read back correctly across large binary carries such as 127 to 128.
- R9: Hits whose high and low phases each last at least one clock cycle are all counted, with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | 1 | Asynchronous discriminator output, one pulse per hit |
| train_start | input | 1 | One-cycle strobe that rearms the block for a new train |
| slice_switch | input | 1 | One-cycle strobe marking a slice boundary |
| rd_strobe | input | 1 | One-cycle request for the next stored entry |
| rd_data | output | 8 | Stored count of the entry being read, binary |
| rd_ovf | output | 1 | Overflow flag of the entry being read |
| rd_valid | output | 1 | High for one cycle when `rd_data`/`rd_ovf` carry a new entry |

## Verification
The two functions that can collide are a hit event and a slice switch landing in the same cycle. The bench provokes this by raising `hit_in` exactly two clock edges before it asserts `slice_switch`, so the synchronized hit event and the bank write share one clock edge. The outcome is judged on readout. The closing slice must hold only the hits that came before the collision, and the following slice must hold exactly one, so the colliding hit is neither lost nor counted twice.

// File: rtl/pix_pkg.sv
package pix_pkg;
  parameter int unsigned PIX_CNT_W  = 8;
  parameter int unsigned PIX_SLICES = 16;
  parameter int unsigned PIX_SYNC   = 2;
endpackage

// File: rtl/pix_hit_edge.sv
module pix_hit_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_in,
  output logic hit_pulse
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], hit_in};
      last_q <= sync_q[TOP];
    end
  end

  // one event per rising edge of the synchronized level
  assign hit_pulse = sync_q[TOP] & ~last_q;
endmodule

// File: rtl/pix_gray_counter.sv
module pix_gray_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             restart,
  input  logic             inc,
  output logic [CNT_W-1:0] gray,
  output logic             ovf
);
  // Gray image of the all-ones binary value: MSB set, rest clear
  localparam logic [CNT_W-1:0] GRAY_MAX = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] GRAY_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] bin_cur;
  logic [CNT_W-1:0] bin_inc;
  logic [CNT_W-1:0] gray_nxt;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      bin_cur[i] = ^(gray >> i);
    end
    bin_inc  = bin_cur + 1'b1;
    gray_nxt = bin_inc ^ (bin_inc >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      gray <= '0;
      ovf  <= 1'b0;
    end else if (restart) begin
      gray <= inc ? GRAY_ONE : '0;
      ovf  <= 1'b0;
    end else if (inc) begin
      if (gray == GRAY_MAX) ovf  <= 1'b1;
      else                  gray <= gray_nxt;
    end
  end
endmodule

// File: rtl/pix_slice_bank.sv
module pix_slice_bank #(
  parameter int unsigned WORD_W   = 9,
  parameter int unsigned N_SLICES = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clear,
  input  logic                            switch_req,
  input  logic [WORD_W-1:0]               wr_word,
  input  logic                            rd_strobe,
  output logic                            accept,
  output logic [$clog2(N_SLICES):0]       slice_idx,
  output logic [WORD_W-1:0]               rd_word,
  output logic                            rd_valid
);
  localparam int unsigned IDX_W = $clog2(N_SLICES);
  localparam logic [IDX_W:0]   IDX_END = (IDX_W+1)'(N_SLICES);
  localparam logic [IDX_W-1:0] PTR_TOP = IDX_W'(N_SLICES - 1);

  logic [WORD_W-1:0] mem [N_SLICES];
  logic [IDX_W-1:0]  rd_ptr;

  assign accept = switch_req && (slice_idx < IDX_END);

  // storage written without reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (accept && !clear) mem[slice_idx[IDX_W-1:0]] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word <= '0;
    end else if (rd_strobe) begin
      rd_word <= mem[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      slice_idx <= '0;
      rd_ptr    <= '0;
      rd_valid  <= 1'b0;
    end else begin
      if (accept) slice_idx <= slice_idx + 1'b1;
      if (rd_strobe) rd_ptr <= (rd_ptr == PTR_TOP) ? '0 : rd_ptr + 1'b1;
      rd_valid <= rd_strobe;
    end
  end
endmodule

// File: rtl/pix_slice_counter.sv
module pix_slice_counter #(
  parameter int unsigned CNT_W       = pix_pkg::PIX_CNT_W,
  parameter int unsigned N_SLICES    = pix_pkg::PIX_SLICES,
  parameter int unsigned SYNC_STAGES = pix_pkg::PIX_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_in,
  input  logic             train_start,
  input  logic             slice_switch,
  input  logic             rd_strobe,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_ovf,
  output logic             rd_valid
);
  localparam int unsigned WORD_W = CNT_W + 1;
  localparam int unsigned IDX_W  = $clog2(N_SLICES);

  logic             hit_pulse;
  logic             accept;
  logic [CNT_W-1:0] cnt_gray;
  logic             cnt_ovf;
  logic [IDX_W:0]   slice_idx;
  logic [WORD_W-1:0] rd_word;

  pix_hit_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .hit_in(hit_in), .hit_pulse(hit_pulse)
  );

  pix_gray_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(train_start), .restart(accept),
    .inc(hit_pulse), .gray(cnt_gray), .ovf(cnt_ovf)
  );

  pix_slice_bank #(.WORD_W(WORD_W), .N_SLICES(N_SLICES)) u_bank (
    .clk(clk), .rst(rst), .clear(train_start), .switch_req(slice_switch),
    .wr_word({cnt_ovf, cnt_gray}), .rd_strobe(rd_strobe), .accept(accept),
    .slice_idx(slice_idx), .rd_word(rd_word), .rd_valid(rd_valid)
  );

  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      rd_data[i] = ^(rd_word[CNT_W-1:0] >> i);
    end
  end
  assign rd_ovf = rd_word[CNT_W];
endmodule

// File: rtl/pix_slice_counter_chk.sv
module pix_slice_counter_chk #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned N_SLICES = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      train_start,
  input logic                      rd_strobe,
  input logic                      rd_valid,
  input logic                      hit_pulse,
  input logic                      accept,
  input logic [CNT_W-1:0]          cnt_gray,
  input logic                      cnt_ovf,
  input logic [$clog2(N_SLICES):0] slice_idx
);
  localparam int unsigned IDX_W = $clog2(N_SLICES);
  localparam logic [CNT_W-1:0] GMAX = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [IDX_W:0]   IEND = (IDX_W+1)'(N_SLICES);

  p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
    hit_pulse |=> !hit_pulse);

  p_gray_step_r8: assert property (@(posedge clk) disable iff (rst)
    (!train_start && !accept) |=> ($countones(cnt_gray ^ $past(cnt_gray)) <= 1));

  p_saturate_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_gray == GMAX && !train_start && !accept) |=> (cnt_gray == GMAX));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_gray == GMAX && hit_pulse && !train_start && !accept) |=> cnt_ovf);

  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit_pulse && !train_start) |=> (cnt_gray == '0 && !cnt_ovf));

  p_idx_bound_r5: assert property (@(posedge clk) disable iff (rst)
    slice_idx <= IEND);

  p_idx_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (slice_idx == IEND && !train_start) |=> (slice_idx == IEND));

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    train_start |=> (cnt_gray == '0 && slice_idx == '0));

  p_valid_on_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !train_start) |=> rd_valid);

  p_valid_off_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> !rd_valid);
endmodule

bind pix_slice_counter pix_slice_counter_chk #(.CNT_W(CNT_W), .N_SLICES(N_SLICES)) u_chk (
  .clk(clk), .rst(rst), .train_start(train_start), .rd_strobe(rd_strobe),
  .rd_valid(rd_valid), .hit_pulse(hit_pulse), .accept(accept),
  .cnt_gray(cnt_gray), .cnt_ovf(cnt_ovf), .slice_idx(slice_idx)
);

// File: tb/tb_pix_slice_counter.sv
`timescale 1ns/1ps
module tb_pix_slice_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hit_in = 1'b0;
  logic       train_start = 1'b0;
  logic       slice_switch = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic       rd_ovf;
  logic       rd_valid;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pix_slice_counter dut (
    .clk(clk), .rst(rst), .hit_in(hit_in), .train_start(train_start),
    .slice_switch(slice_switch), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .rd_ovf(rd_ovf), .rd_valid(rd_valid)
  );

  // stimulus and expected vectors, one row per slice
  localparam int HITS [16] = '{0, 1, 2, 5, 17, 3, 300, 255, 9, 1, 0, 40, 7, 128, 2, 64};
  localparam int WID  [16] = '{1, 3, 1, 1, 8, 1, 1, 1, 5, 20, 1, 2, 1, 1, 4, 1};
  localparam int EXPC [16] = '{0, 1, 2, 5, 17, 3, 255, 255, 9, 1, 0, 40, 7, 128, 2, 64};
  localparam int EOVF [16] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam string TAG [16] = '{"R5", "R4", "R4", "R9", "R2", "R4", "R3", "R3",
                                 "R2", "R2", "R4", "R9", "R4", "R8", "R2", "R4"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_hits(input int n, input int w);
    for (int k = 0; k < n; k++) begin
      hit_in = 1'b1;
      repeat (w) @(negedge clk);
      hit_in = 1'b0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_switch();
    slice_switch = 1'b1;
    @(negedge clk);
    slice_switch = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_train();
    train_start = 1'b1;
    @(negedge clk);
    train_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_one(input string req, input int exp_cnt, input int exp_ovf);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    check(rd_valid === 1'b1, req, int'(rd_valid), 1);
    check(rd_data == 8'(exp_cnt), req, int'(rd_data), exp_cnt);
    check(rd_ovf == 1'(exp_ovf), req, int'(rd_ovf), exp_ovf);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(rd_valid === 1'b0, "R1", int'(rd_valid), 0);
    check(rd_data === 8'd0, "R1", int'(rd_data), 0);
    check(rd_ovf === 1'b0, "R1", int'(rd_ovf), 0);

    // table walk: one train, one row per slice
    pulse_train();
    for (int s = 0; s < 16; s++) begin
      send_hits(HITS[s], WID[s]);
      pulse_switch();
    end
    // R5: switch beyond the last slice must not disturb any entry
    send_hits(5, 1);
    pulse_switch();
    for (int s = 0; s < 16; s++) begin
      read_one(TAG[s], EXPC[s], EOVF[s]);
    end
    // R7: valid drops after the strobe, pointer wraps to slice 0
    check(rd_valid === 1'b0, "R7", int'(rd_valid), 0);
    read_one("R7", EXPC[0], EOVF[0]);

    // R6 and R4: restart mid-train, then hit coinciding with a switch
    pulse_train();
    send_hits(4, 2);
    pulse_train();
    send_hits(3, 2);
    hit_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    slice_switch = 1'b1;
    @(negedge clk);
    slice_switch = 1'b0;
    hit_in = 1'b0;
    repeat (4) @(negedge clk);
    pulse_switch();
    read_one("R6", 3, 0);
    read_one("R4", 1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule